// File: doc/BRIEF.md
# Bit-Serial Soft-Decision Viterbi Decoder

This block decodes a rate 1/2 convolutional code with constraint length 5, so its trellis has 16 states. Each received symbol carries two 3-bit soft values, which are taken in together through a valid/ready handshake. Inside, the branch metrics become serial bit streams. Sixteen add-compare-select nodes, one per state, then work at the same time. Each node reads the path metrics of its two predecessors over single-bit links, least significant bit first.

Survivor paths are kept by register exchange. Each trellis step, every state copies the survivor word of the predecessor that won and appends its own newest input bit. The links follow the butterfly pattern: predecessors 2j and 2j+1 feed successors j and j+8. Decoded bits are read from the oldest position of the survivor of state 0. Each one is marked by a one-cycle valid strobe.

Top module: `viterbi_serial_dec`

## Requirements
- R1: After a synchronous reset, in_ready is 1 and out_valid is 0. The path metric of state 0 is 0, and every other state's metric is all ones, so decoding starts from state 0.
- R2: A symbol is accepted on a clock edge where in_valid and in_ready are both 1. After that edge, in_ready is 0 for exactly 9 cycles: 8 serial metric clocks and 1 latch clock. It is 1 again in the 10th cycle.
- R3: A soft value of 0 means a confident 0 and a value of 7 means a confident 1. The branch cost of expecting bit c from soft value y is y when c is 0 and 7-y when c is 1. The branch metric is the sum of the costs for soft_a (the first code bit) and soft_b (the second code bit).
- R4: The encoder register is {u, s}. The state s holds the previous four inputs, with the most recent at bit 3. The next state is {u, s[3:1]}. The first code bit is u_t^u_(t-3)^u_(t-4), which is generator 23 octal. The second is u_t^u_(t-1)^u_(t-2)^u_(t-4), which is generator 35 octal.
- R5: Each state picks the predecessor with the smaller sum of path metric and branch metric. A sum carried past 8 bits counts as larger than any sum that fits in 8 bits. On a tie the even predecessor 2j wins.
- R6: When the new metrics of all 16 states have their most significant bit set, that bit is cleared in every metric. As a result, between steps at least one state metric always has its top bit clear. Long noisy streams decode without metric overflow.
- R7: out_valid first pulses after the 32nd accepted symbol. It appears in the same cycle in which in_ready returns to 1.
- R8: The k-th out_bit marked by out_valid is the decoder's estimate of the k-th input bit. It equals that bit for noise-free input and for sparse correctable errors.
- R9: out_valid is high for exactly one cycle per accepted symbol once 32 symbols have been accepted. N symbols give N-31 outputs.
- R10: in_valid and the soft inputs are ignored while in_ready is 0. Garbage presented during busy cycles does not change the decoded stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Soft symbol pair present |
| in_ready | output | 1 | Decoder can take a symbol this cycle |
| soft_a | input | 3 | Soft value of the first code bit |
| soft_b | input | 3 | Soft value of the second code bit |
| out_valid | output | 1 | One-cycle strobe marking out_bit |
| out_bit | output | 1 | Decoded bit, oldest survivor position of state 0 |

## Verification
Several properties are checked on every cycle: the busy window after an accept, that out_valid is a single-cycle pulse following a latch cycle, the reset metric of state 0, and the headroom rule that some metric keeps its top bit clear between steps. Other behaviour is visible only through the bench scenarios: that the selection, the branch costs and the butterfly wiring really find the transmitted path, that normalisation keeps long noisy runs correct, and that garbage offered during busy cycles is ignored. The bench shows these by re-encoding known bit streams with its own tap equations and comparing every decoded bit.

// File: rtl/vd_pkg.sv
`timescale 1ns/1ps
package vd_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_LATCH} vd_phase_e;

  // Expected code pair for input u leaving state s; bit 1 is the first code bit.
  function automatic logic [1:0] code_pair(input int k, input int g0, input int g1,
                                           input int u, input int s);
    int r;
    r = (u << (k - 1)) | s;
    return {^(r & g0), ^(r & g1)};
  endfunction

  // Cost of expecting code bit c from a soft value y of width w.
  function automatic int branch_cost(input int w, input int y, input int c);
    return (c != 0) ? ((1 << w) - 1 - y) : y;
  endfunction

  function automatic logic carry_out(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

  // Borrow out of x - y - bin.
  function automatic logic borrow_out(input logic x, input logic y, input logic bin);
    return (~x & y) | (~(x ^ y) & bin);
  endfunction

endpackage

// File: rtl/vd_ctrl.sv
`timescale 1ns/1ps
module vd_ctrl import vd_pkg::*; #(
  parameter int PM_W  = 8,
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic run,
  output logic latch,
  output logic out_valid
);
  localparam int CW = (PM_W > 1) ? $clog2(PM_W) : 1;
  localparam int SW = $clog2(DEPTH + 1);

  vd_phase_e       phase;
  logic [CW-1:0]   cnt;
  logic [SW-1:0]   steps;

  assign in_ready = (phase == PH_IDLE);
  assign accept   = in_ready & in_valid;
  assign run      = (phase == PH_RUN);
  assign latch    = (phase == PH_LATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      steps     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (in_valid) begin
            phase <= PH_RUN;
            cnt   <= '0;
          end
        end
        PH_RUN: begin
          if (cnt == CW'(PM_W - 1)) phase <= PH_LATCH;
          else                      cnt   <= cnt + 1'b1;
        end
        PH_LATCH: begin
          phase     <= PH_IDLE;
          out_valid <= (steps >= SW'(DEPTH - 1));
          if (steps != SW'(DEPTH)) steps <= steps + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vd_bm_serial.sv
`timescale 1ns/1ps
module vd_bm_serial import vd_pkg::*; #(
  parameter int SOFT_W = 3,
  parameter int PM_W   = 8
) (
  input  logic              clk,
  input  logic              load,
  input  logic              shift,
  input  logic [SOFT_W-1:0] y0,
  input  logic [SOFT_W-1:0] y1,
  output logic [3:0]        bm_bit
);
  // One shift register per expected code pair, sent LSB first.
  for (genvar k = 0; k < 4; k++) begin : g_pair
    logic [PM_W-1:0] sr;
    always_ff @(posedge clk) begin
      if (load)
        sr <= PM_W'(branch_cost(SOFT_W, int'(y0), (k >> 1) & 1) +
                    branch_cost(SOFT_W, int'(y1), k & 1));
      else if (shift)
        sr <= sr >> 1;
    end
    assign bm_bit[k] = sr[0];
  end
endmodule

// File: rtl/vd_acs.sv
`timescale 1ns/1ps
module vd_acs import vd_pkg::*; #(
  parameter int PM_W      = 8,
  parameter bit INIT_ZERO = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            run,
  input  logic            latch,
  input  logic            norm,
  input  logic            pa,
  input  logic            pb,
  input  logic            ba,
  input  logic            bb,
  output logic            pm_lsb,
  output logic            win_msb,
  output logic            pick_b,
  output logic [PM_W-1:0] pm_q
);
  localparam logic [PM_W-1:0] INIT     = INIT_ZERO ? {PM_W{1'b0}} : {PM_W{1'b1}};
  localparam logic [PM_W-1:0] MSB_MASK = {1'b0, {(PM_W-1){1'b1}}};

  logic [PM_W-1:0] sa, sb, win;
  logic            ca, cb, bo;
  logic            sbit_a, sbit_b;

  assign sbit_a = pa ^ ba ^ ca;
  assign sbit_b = pb ^ bb ^ cb;

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_q <= INIT;
      ca   <= 1'b0;
      cb   <= 1'b0;
      bo   <= 1'b0;
    end else if (clr) begin
      ca <= 1'b0;
      cb <= 1'b0;
      bo <= 1'b0;
    end else if (run) begin
      ca   <= carry_out(pa, ba, ca);
      cb   <= carry_out(pb, bb, cb);
      bo   <= borrow_out(sbit_b, sbit_a, bo);
      pm_q <= pm_q >> 1;
    end else if (latch) begin
      pm_q <= norm ? (win & MSB_MASK) : win;
    end
  end

  always_ff @(posedge clk) begin
    if (run) begin
      sa <= {sbit_a, sa[PM_W-1:1]};
      sb <= {sbit_b, sb[PM_W-1:1]};
    end
  end

  // b wins only when strictly smaller; a carried sum counts as larger.
  assign pick_b  = (ca != cb) ? ca : bo;
  assign win     = pick_b ? (cb ? {PM_W{1'b1}} : sb) : (ca ? {PM_W{1'b1}} : sa);
  assign win_msb = win[PM_W-1];
  assign pm_lsb  = pm_q[0];
endmodule

// File: rtl/vd_surv.sv
`timescale 1ns/1ps
module vd_surv #(
  parameter int NS    = 16,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          latch,
  input  logic [NS-1:0] pick,
  output logic          oldest_next
);
  localparam int HALF = NS / 2;

  logic [DEPTH-1:0] surv [NS];
  logic [DEPTH-1:0] nxt  [NS];

  for (genvar n = 0; n < NS; n++) begin : g_state
    localparam int PE = 2 * (n % HALF);
    logic [DEPTH-1:0] src;
    assign src    = pick[n] ? surv[PE + 1] : surv[PE];
    assign nxt[n] = (src << 1) | DEPTH'(n / HALF);
    always_ff @(posedge clk) begin
      if (rst)        surv[n] <= '0;
      else if (latch) surv[n] <= nxt[n];
    end
  end

  assign oldest_next = nxt[0][DEPTH-1];
endmodule

// File: rtl/viterbi_serial_dec.sv
`timescale 1ns/1ps
module viterbi_serial_dec import vd_pkg::*; #(
  parameter int K      = 5,
  parameter int G0     = 19,
  parameter int G1     = 29,
  parameter int SOFT_W = 3,
  parameter int PM_W   = 8,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SOFT_W-1:0] soft_a,
  input  logic [SOFT_W-1:0] soft_b,
  output logic              out_valid,
  output logic              out_bit
);
  localparam int NS   = 1 << (K - 1);
  localparam int HALF = NS / 2;

  logic            accept_evt, run_evt, latch_evt;
  logic [3:0]      bm_bit;
  logic [NS-1:0]   lsb_vec, win_msb_vec, pick_vec, pm_msb_vec;
  logic [PM_W-1:0] pm_all [NS];
  logic [PM_W-1:0] pm0_val;
  logic            norm_now, oldest_next;

  vd_ctrl #(.PM_W(PM_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept_evt), .run(run_evt), .latch(latch_evt), .out_valid(out_valid)
  );

  vd_bm_serial #(.SOFT_W(SOFT_W), .PM_W(PM_W)) u_bm (
    .clk(clk), .load(accept_evt), .shift(run_evt),
    .y0(soft_a), .y1(soft_b), .bm_bit(bm_bit)
  );

  assign norm_now = &win_msb_vec;

  for (genvar n = 0; n < NS; n++) begin : g_node
    localparam int PE = 2 * (n % HALF);
    localparam int UB = n / HALF;
    localparam logic [1:0] CA = code_pair(K, G0, G1, UB, PE);
    localparam logic [1:0] CB = code_pair(K, G0, G1, UB, PE + 1);
    vd_acs #(.PM_W(PM_W), .INIT_ZERO(n == 0)) u_acs (
      .clk(clk), .rst(rst), .clr(accept_evt), .run(run_evt), .latch(latch_evt),
      .norm(norm_now), .pa(lsb_vec[PE]), .pb(lsb_vec[PE + 1]),
      .ba(bm_bit[CA]), .bb(bm_bit[CB]), .pm_lsb(lsb_vec[n]),
      .win_msb(win_msb_vec[n]), .pick_b(pick_vec[n]), .pm_q(pm_all[n])
    );
    assign pm_msb_vec[n] = pm_all[n][PM_W-1];
  end

  assign pm0_val = pm_all[0];

  vd_surv #(.NS(NS), .DEPTH(DEPTH)) u_surv (
    .clk(clk), .rst(rst), .latch(latch_evt), .pick(pick_vec), .oldest_next(oldest_next)
  );

  always_ff @(posedge clk) begin
    if (rst)            out_bit <= 1'b0;
    else if (latch_evt) out_bit <= oldest_next;
  end
endmodule

// File: rtl/vd_sva.sv
`timescale 1ns/1ps
module vd_sva #(
  parameter int NS   = 16,
  parameter int PM_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            out_valid,
  input logic            accept_evt,
  input logic            run_evt,
  input logic            latch_evt,
  input logic [NS-1:0]   msb_vec,
  input logic [PM_W-1:0] pm0
);
  logic seen_latch;
  always_ff @(posedge clk) begin
    if (rst)            seen_latch <= 1'b0;
    else if (latch_evt) seen_latch <= 1'b1;
  end

  p_reset_start_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pm0 == '0) && in_ready && !out_valid);

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> !in_ready);

  p_run_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
    run_evt |-> !in_ready);

  p_headroom_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_latch && in_ready) |-> !(&msb_vec));

  p_strobe_follows_latch_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(latch_evt));

  p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

bind viterbi_serial_dec vd_sva #(.NS(NS), .PM_W(PM_W)) i_sva (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .accept_evt(accept_evt), .run_evt(run_evt), .latch_evt(latch_evt),
  .msb_vec(pm_msb_vec), .pm0(pm0_val)
);

// File: tb/test_viterbi_serial_dec.sv
`timescale 1ns/1ps
module test_viterbi_serial_dec;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] soft_a = '0;
  logic [2:0] soft_b = '0;
  wire        in_ready, out_valid, out_bit;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    out_idx = 0;
  bit    tx[$];
  string scen_tag = "R1";

  viterbi_serial_dec i_viterbi_serial_dec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .soft_a(soft_a), .soft_b(soft_b), .out_valid(out_valid), .out_bit(out_bit)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit hist(input int d);
    int i;
    i = tx.size() - 1 - d;
    return (i >= 0) ? tx[i] : 1'b0;
  endfunction

  // R4 taps written as delays: 23 octal -> t, t-3, t-4; 35 octal -> t, t-1, t-2, t-4.
  function automatic logic [1:0] tb_encode();
    bit a, b;
    a = hist(0) ^ hist(3) ^ hist(4);
    b = hist(0) ^ hist(1) ^ hist(2) ^ hist(4);
    return {a, b};
  endfunction

  // R3 soft scale: 0 confident zero, 7 confident one. mode 0 clean, 1 jitter, 2 wrong side.
  function automatic logic [2:0] soft_of(input bit c, input int mode);
    int v;
    if (mode == 0)      v = c ? 7 : 0;
    else if (mode == 1) v = c ? 7 - int'($urandom % 4) : int'($urandom % 4);
    else                v = c ? 1 : 6;
    return 3'(v);
  endfunction

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (out_idx < tx.size())
        check(out_bit == tx[out_idx], scen_tag, int'(out_bit), int'(tx[out_idx]));
      else
        check(1'b0, "R9 output beyond input count", out_idx, tx.size() - 1);
      out_idx++;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tx.delete();
    out_idx = 0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic send_sym(input bit u, input int mode, input bit garbage);
    logic [1:0] c;
    int lows;
    tx.push_back(u);
    c = tb_encode();
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    soft_a = soft_of(c[1], mode);
    soft_b = soft_of(c[0], (mode == 2) ? 1 : mode);
    @(negedge clk);
    if (garbage) begin
      in_valid = 1'b1;
      soft_a = 3'($urandom);
      soft_b = 3'($urandom);
    end else begin
      in_valid = 1'b0;
    end
    lows = 0;
    while (!in_ready && lows < 40) begin
      lows++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(lows == 9, "R2 busy cycles after accept", lows, 9);
    check(out_valid == (tx.size() >= DEPTH), "R7 strobe timing", int'(out_valid),
          int'(tx.size() >= DEPTH));
  endtask

  task automatic run_scen(input string tag, input int n, input int pattern,
                          input int noise, input bit garbage);
    do_reset();
    scen_tag = tag;
    for (int i = 0; i < n; i++) begin
      bit u;
      int m;
      case (pattern)
        0:       u = 1'b0;
        1:       u = 1'b1;
        2:       u = (i % 3 == 0);
        default: u = 1'($urandom % 2);
      endcase
      if (noise == 0)                      m = 0;
      else if (noise == 2 && i % 25 == 12) m = 2;
      else                                 m = 1;
      send_sym(u, m, garbage);
    end
    repeat (3) @(negedge clk);
    check(out_idx == n - DEPTH + 1, "R9 output count", out_idx, n - DEPTH + 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_scen("R8 R4 clean zeros", 40, 0, 0, 1'b0);
    run_scen("R8 R4 clean ones", 40, 1, 0, 1'b0);
    run_scen("R8 R5 R3 clean pattern", 60, 2, 0, 1'b0);
    run_scen("R8 R3 R5 jittered random", 120, 3, 1, 1'b0);
    run_scen("R8 R6 long run with flips", 300, 3, 2, 1'b0);
    run_scen("R10 garbage during busy", 80, 3, 1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule